// File: doc/BRIEF.md
# Embedded Program/Erase Status Engine

This block carries out a byte program or a region erase on a small behavioural byte array once a start request has been accepted. The operation runs for a fixed number of clock cycles, and no host action is needed during that time. While it runs, the read port does not return array contents. It returns a status byte that lets the host poll for completion. When the timer expires, the block goes back to plain array reads by itself.

The array is split into equal regions. Each region is selected by the top address bits. An erase walks the whole array one byte per cycle and writes FF into every byte whose region is selected. A program merges the new data into the stored byte with an AND, so a program can only clear bits. A power-on window after reset blocks every start, and pulling reset low aborts any operation still in flight.

Top module: `flash_status_engine`

## Requirements
- R1: While `rst_n` is low, `busy`, `rd_data` and `wr_en` are 0. An operation cut short by reset makes no later write, so a byte whose program was aborted keeps its old value.
- R2: Every start request is ignored for the first POR_CYCLES clock edges after reset is released.
- R3: After an accepted start, `busy` rises at the next clock edge. It stays high for exactly PROG_CYCLES cycles for a program and exactly ERASE_CYCLES cycles for an erase, then drops on its own.
- R4: A program leaves the addressed byte equal to its old value ANDed with `prog_data`. No other byte changes.
- R5: A chip erase writes FF to every byte whose region bit in `chip_mask` is 1, and leaves the other bytes unchanged. The region of an address is its top REGION_W bits, and bit i of the mask selects region i.
- R6: A sector erase writes FF to every byte of the single region numbered `sector_sel`, and leaves all other bytes unchanged.
- R7: A read issued while busy returns, in bit 7, the complement of bit 7 of the programmed data during a program, and 0 during an erase.
- R8: Bit 6 of consecutive reads issued while busy alternates between 0 and 1.
- R9: Bits 5..0 of a read issued while busy repeat bits 5..0 of the previous read result.
- R10: Start requests that arrive while busy are ignored, and they do not change the length or the effect of the running operation. When several starts arrive in the same cycle, program wins over chip erase, and chip erase wins over sector erase.
- R11: When not busy, a read returns the array byte at `rd_addr` in `rd_data` one cycle after `rd_en`.
- R12: `wr_en` is high only while busy. Erase writes carry FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; aborts any operation |
| prog_start | input | 1 | Request a byte program |
| prog_addr | input | ADDR_W | Program address |
| prog_data | input | 8 | Program data |
| chip_erase_start | input | 1 | Request a masked erase |
| chip_mask | input | 2**REGION_W | Regions to erase, one bit each |
| sector_erase_start | input | 1 | Request a single-region erase |
| sector_sel | input | REGION_W | Region to erase |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| busy | output | 1 | Operation in progress |
| rd_data | output | 8 | Registered read data or status byte |
| wr_en | output | 1 | Array write strobe |
| wr_addr | output | ADDR_W | Array write address |
| wr_data | output | 8 | Array write data |

## Verification
The hardest case to reach is a start request, or a second and competing request, that arrives in the middle of a running operation. A cross-check is needed to show that such a request changes neither the duration nor the array. The bench injects a sector erase on the first busy cycle of a program while it polls every cycle. It then measures the busy length and rereads the whole array against its own model. Aborting a program with reset, and issuing a start in the first cycle after reset, are reached the same way: the bench times them in cycles from the accepting edge.

// File: rtl/flash_status_engine.sv
module flash_status_engine #(
  parameter int ADDR_W       = 6,
  parameter int REGION_W     = 2,
  parameter int PROG_CYCLES  = 6,
  parameter int ERASE_CYCLES = 80,
  parameter int POR_CYCLES   = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     prog_start,
  input  logic [ADDR_W-1:0]        prog_addr,
  input  logic [7:0]               prog_data,
  input  logic                     chip_erase_start,
  input  logic [(1<<REGION_W)-1:0] chip_mask,
  input  logic                     sector_erase_start,
  input  logic [REGION_W-1:0]      sector_sel,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic                     busy,
  output logic [7:0]               rd_data,
  output logic                     wr_en,
  output logic [ADDR_W-1:0]        wr_addr,
  output logic [7:0]               wr_data
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int REGIONS = 1 << REGION_W;
  localparam int CNT_W   = $clog2(ERASE_CYCLES + PROG_CYCLES + 1);
  localparam int POR_W   = $clog2(POR_CYCLES + 1);
  localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYCLES - 1);
  localparam logic [CNT_W-1:0] DEPTH_C    = CNT_W'(DEPTH);
  localparam logic [POR_W-1:0] POR_LAST   = POR_W'(POR_CYCLES);

  logic [7:0]         mem [DEPTH];
  logic [POR_W-1:0]   por_cnt;
  logic               is_erase, tog;
  logic [CNT_W-1:0]   cnt;
  logic [ADDR_W-1:0]  op_addr;
  logic [7:0]         op_data;
  logic [REGIONS-1:0] op_mask;

  wire por_done = (por_cnt == POR_LAST);
  wire accept   = por_done && !busy && (prog_start || chip_erase_start || sector_erase_start);

  wire [CNT_W-1:0]  sweep_idx  = ERASE_LAST - cnt;
  wire              in_sweep   = sweep_idx < DEPTH_C;
  wire [ADDR_W-1:0] sweep_addr = sweep_idx[ADDR_W-1:0];

  assign wr_en   = busy && (is_erase ? (in_sweep && op_mask[sweep_addr[ADDR_W-1 -: REGION_W]])
                                     : (cnt == '0));
  assign wr_addr = is_erase ? sweep_addr : op_addr;
  assign wr_data = is_erase ? 8'hFF : (mem[op_addr] & op_data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      por_cnt  <= '0;
      busy     <= 1'b0;
      is_erase <= 1'b0;
      cnt      <= '0;
      op_addr  <= '0;
      op_data  <= '0;
      op_mask  <= '0;
      tog      <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (!por_done) por_cnt <= por_cnt + 1'b1;

      if (accept) begin
        busy <= 1'b1;
        if (prog_start) begin
          is_erase <= 1'b0;
          cnt      <= PROG_LAST;
          op_addr  <= prog_addr;
          op_data  <= prog_data;
        end else if (chip_erase_start) begin
          is_erase <= 1'b1;
          cnt      <= ERASE_LAST;
          op_mask  <= chip_mask;
        end else begin
          is_erase <= 1'b1;
          cnt      <= ERASE_LAST;
          op_mask  <= REGIONS'(1) << sector_sel;
        end
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end

      if (rd_en) begin
        if (busy) begin
          rd_data <= {is_erase ? 1'b0 : ~op_data[7], tog, rd_data[5:0]};
          tog     <= ~tog;
        end else begin
          rd_data <= mem[rd_addr];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end
endmodule

// File: rtl/flash_status_engine_chk.sv
module flash_status_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       rd_en,
  input logic [7:0] rd_data,
  input logic       wr_en,
  input logic       start_any,
  input logic       por_done,
  input logic       cnt_zero
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !busy);

  // R2
  por_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !por_done |=> !busy);

  // R3
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_any && por_done));

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cnt_zero) |=> busy);

  // R12
  write_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  // R8
  toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy && $past(rd_en && busy)) |=> (rd_data[6] != $past(rd_data[6])));

  // R9
  low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy) |=> (rd_data[5:0] == $past(rd_data[5:0])));
endmodule

bind flash_status_engine flash_status_engine_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .rd_en    (rd_en),
  .rd_data  (rd_data),
  .wr_en    (wr_en),
  .start_any(prog_start || chip_erase_start || sector_erase_start),
  .por_done (por_done),
  .cnt_zero (cnt == '0)
);

// File: tb/flash_status_engine_bench.sv
module flash_status_engine_bench;
  localparam int AW = 6, RW = 2, PC = 6, EC = 80, POR = 10;
  localparam int DEPTH = 1 << AW, NREG = 1 << RW;

  logic clk = 0, rst_n = 0;
  logic prog_start = 0, chip_erase_start = 0, sector_erase_start = 0, rd_en = 0;
  logic [AW-1:0] prog_addr = '0, rd_addr = '0;
  logic [7:0] prog_data = '0;
  logic [NREG-1:0] chip_mask = '0;
  logic [RW-1:0] sector_sel = '0;
  logic busy, wr_en;
  logic [7:0] rd_data, wr_data;
  logic [AW-1:0] wr_addr;

  int checks = 0, errors = 0;
  logic [7:0] model [DEPTH];

  always #2 clk = ~clk;

  flash_status_engine #(.ADDR_W(AW), .REGION_W(RW), .PROG_CYCLES(PC),
                        .ERASE_CYCLES(EC), .POR_CYCLES(POR)) u_flash_status_engine (
    .clk, .rst_n, .prog_start, .prog_addr, .prog_data, .chip_erase_start, .chip_mask,
    .sector_erase_start, .sector_sel, .rd_en, .rd_addr, .busy, .rd_data,
    .wr_en, .wr_addr, .wr_data);

  task automatic step(); @(posedge clk); #1; endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    rd_en = 1; rd_addr = a; step(); rd_en = 0; d = rd_data;
  endtask

  task automatic verify_all(string req);
    logic [7:0] d;
    for (int a = 0; a < DEPTH; a++) begin
      rd(AW'(a), d);
      check(d == model[a], req, d, model[a]);
    end
  endtask

  // runs after the accepting edge; polls while busy, optional injected start
  task automatic run_op(int len, bit is_erase, logic [7:0] pdata, bit poll, bit inject);
    int n = 0; bit have = 0; logic prev6 = 0; logic [5:0] low = rd_data[5:0];
    while (busy && n < 1000) begin
      rd_en = poll;
      if (inject && n == 0) begin sector_erase_start = 1; sector_sel = 2'd3; end
      step(); n++;
      sector_erase_start = 0;
      if (poll) begin
        check(rd_data[7] == (is_erase ? 1'b0 : ~pdata[7]), "R7", rd_data[7], is_erase ? 0 : ~pdata[7]);
        check(rd_data[5:0] == low, "R9", rd_data[5:0], low);
        if (have) check(rd_data[6] != prev6, "R8", rd_data[6], ~prev6);
        prev6 = rd_data[6]; have = 1;
      end
    end
    rd_en = 0;
    check(n == len, inject ? "R10" : "R3", n, len);
  endtask

  task automatic do_prog(logic [AW-1:0] a, logic [7:0] d, bit poll);
    prog_start = 1; prog_addr = a; prog_data = d; step(); prog_start = 0;
    model[a] = model[a] & d;
    run_op(PC, 0, d, poll, 0);
  endtask

  task automatic do_chip(logic [NREG-1:0] m);
    chip_erase_start = 1; chip_mask = m; step(); chip_erase_start = 0;
    for (int a = 0; a < DEPTH; a++) if (m[a >> (AW-RW)]) model[a] = 8'hFF;
    run_op(EC, 1, 8'h00, 1, 0);
  endtask

  task automatic do_sector(logic [RW-1:0] s);
    sector_erase_start = 1; sector_sel = s; step(); sector_erase_start = 0;
    for (int a = 0; a < DEPTH; a++) if ((a >> (AW-RW)) == s) model[a] = 8'hFF;
    run_op(EC, 1, 8'h00, 0, 0);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d, keep;
    step(); step();
    // R1 reset state
    check(busy == 0 && rd_data == 0 && wr_en == 0, "R1", {busy, wr_en, rd_data}, 0);
    rst_n = 1;
    // R2 start inside power-on window is dropped
    chip_erase_start = 1; chip_mask = '1; step(); chip_erase_start = 0;
    for (int i = 0; i < POR + 2; i++) begin
      check(busy == 0, "R2", busy, 0);
      step();
    end
    do_chip('1);
    verify_all("R5");
    for (int a = 0; a < DEPTH; a++) do_prog(AW'(a), 8'((a * 29 + 7) ^ (a << 3)), a < 4);
    verify_all("R4");
    // R11 idle read returns data next cycle
    rd(AW'(5), d);
    check(d == model[5], "R11", d, model[5]);
    for (int a = 0; a < DEPTH; a += 3) do_prog(AW'(a), 8'((a * 53) ^ 8'hA5), 1);
    verify_all("R4");
    // R10 start while busy ignored
    prog_start = 1; prog_addr = AW'(9); prog_data = 8'h3C; step(); prog_start = 0;
    model[9] = model[9] & 8'h3C;
    run_op(PC, 0, 8'h3C, 1, 1);
    verify_all("R10");
    // R10 priority: program beats chip erase
    prog_start = 1; chip_erase_start = 1; chip_mask = '1; prog_addr = AW'(20); prog_data = 8'h0F;
    step(); prog_start = 0; chip_erase_start = 0;
    model[20] = model[20] & 8'h0F;
    run_op(PC, 0, 8'h0F, 1, 0);
    verify_all("R10");
    do_sector(2'd2);
    verify_all("R6");
    for (int a = 0; a < DEPTH; a++) if (a % 5 == 0) do_prog(AW'(a), 8'h00, 0);
    do_chip(4'b1001);
    verify_all("R5");
    do_sector(2'd0);
    verify_all("R6");
    // R12 erase write data observed at port
    chip_erase_start = 1; chip_mask = 4'b0100; step(); chip_erase_start = 0;
    for (int a = 0; a < DEPTH; a++) if ((a >> (AW-RW)) == 2) model[a] = 8'hFF;
    for (int i = 0; i < EC; i++) begin
      if (wr_en) check(wr_data == 8'hFF && busy, "R12", wr_data, 8'hFF);
      step();
    end
    check(busy == 0, "R3", busy, 0);
    // R1 abort a program with reset
    keep = model[40];
    prog_start = 1; prog_addr = AW'(40); prog_data = 8'h00; step(); prog_start = 0;
    step();
    rst_n = 0; #1;
    check(busy == 0 && rd_data == 0 && wr_en == 0, "R1", {busy, wr_en, rd_data}, 0);
    step(); rst_n = 1;
    for (int i = 0; i < POR + 2; i++) step();
    rd(AW'(40), d);
    check(d == keep && keep != 0, "R1", d, keep);
    verify_all("R1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule